// File: doc/BRIEF.md
# Dual-Buffer Playback Address Sequencer

This block generates the memory read addresses for an audio playback stream that alternates between two buffers. Software programs a 32-bit start address and a 16-bit byte length for each of the two buffers and picks a sample format. It then sets the run bit, together with a rewind strobe that points the sequencer at the beginning of buffer A.

While the block runs, each fetch request from the downstream sample engine is granted with the current byte address. The address then moves forward by the size of one sample frame. When the offset within the active buffer reaches that buffer's length, the block raises a completion flag for that buffer. It then jumps to the start of the other buffer and carries on, so software can refill one buffer while the other plays.

Completion flags are cleared by writing ones back to the status word. The interrupt output stays high while any completion flag is still set.

Top module: `pbk_dma_seq`

## Requirements
- R1: After reset, every buffer start, buffer length, position and offset register reads 0, the control word reads 0, the status word reads 0x0001, the format word reads 0x0010 and `irq` is low.
- R2: Registers are 16-bit words selected by `reg_idx`, and a read returns the addressed word combinationally. The word indices are:
  - 0: control, where bit 0 is run and bit 1 is rewind.
  - 1: status.
  - 2 and 3: buffer A start, low and high halves.
  - 4 and 5: buffer B start, low and high halves.
  - 6: buffer A length.
  - 7: buffer B length.
  - 8 and 9: position, low and high halves.
  - 10: offset.
  - 11: format.
  - Any other index reads 0.
- R3: `fetch_valid` is high exactly when `fetch_req` is high and the run bit is set. While the run bit is clear, position and offset hold their values, and setting the bit again resumes from the same place.
- R4: Writing the control word with bit 1 set loads the position from buffer A's start, clears the offset and makes buffer A active. This takes priority over a fetch in the same cycle. Bit 1 always reads back as 0.
- R5: While `fetch_valid` is high, `fetch_addr` equals the current position. After the grant, position and offset advance by a step size set by the format word:
  - 1 byte when bits 4 and 5 are both clear.
  - 2 bytes when exactly one of them is set (bit 4 is 16-bit, bit 5 is stereo).
  - 4 bytes when both are set.
- R6: If a granted fetch brings the offset to a value greater than or equal to the active buffer's length, the block does three things:
  - It sets that buffer's completion flag (status bit 1 for A, bit 2 for B).
  - It loads the position from the other buffer's start.
  - It clears the offset and makes the other buffer active.
  A length of 0 therefore ends the buffer on every fetch.
- R7: Writing the status word clears each bit 2:0 written as 1, and 0xFFFF clears them all. Bit 0 is set only by reset. Bits 15:3 read 0. A completion that occurs in the same cycle as its own clear leaves the flag set.
- R8: `irq` is high exactly when status bit 1 or bit 2 is set.
- R9: Format bits 5:0 are writable (bits 3:0 hold a rate code that is only stored) and bits 15:6 read 0.
- R10: Writes to the position and offset words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the word at `reg_idx` |
| fetch_req | input | 1 | Request for the next sample address |
| fetch_valid | output | 1 | Request granted this cycle |
| fetch_addr | output | 32 | Byte address of the granted fetch |
| irq | output | 1 | Buffer-completion interrupt |

## Verification
The sequencer is driven with the four step sizes against buffer lengths that are exact multiples of the step and lengths that are not, so an equality-only end test is told apart from the required greater-or-equal test. Fetch requests arrive both back to back and with gaps, and the run bit is dropped mid-buffer, which separates a pause that holds position from one that rewinds. Acknowledges are written single-bit, all-ones and in the same cycle as a completion, which exposes clear-over-set priority mistakes. A zero-length buffer and writes to the read-only position words cover the edge cases.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

   localparam int IX_W = 4;

   typedef enum logic [IX_W-1:0] {
      IX_CTRL   = 4'd0,
      IX_STAT   = 4'd1,
      IX_SA_LO  = 4'd2,
      IX_SA_HI  = 4'd3,
      IX_SB_LO  = 4'd4,
      IX_SB_HI  = 4'd5,
      IX_LEN_A  = 4'd6,
      IX_LEN_B  = 4'd7,
      IX_POS_LO = 4'd8,
      IX_POS_HI = 4'd9,
      IX_OFS    = 4'd10,
      IX_FMT    = 4'd11
   } reg_ix_e;

   localparam logic [5:0] FMT_RESET = 6'h10;

   // bytes per sample frame: 1, 2 or 4
   function automatic logic [2:0] frame_bytes(input logic wide, input logic stereo);
      logic [1:0] sh;
      sh = {1'b0, wide} + {1'b0, stereo};
      return 3'(3'd1 << sh);
   endfunction

endpackage

// File: rtl/pbk_area_bank.sv
module pbk_area_bank
   import pbk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int REG_W  = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IX_W-1:0]                widx,
   input  logic [REG_W-1:0]               wdata,
   output logic [1:0][ADDR_W-1:0]         start_o,
   output logic [1:0][LEN_W-1:0]          len_o
);

   for (genvar a = 0; a < 2; a++) begin : g_area
      localparam logic [IX_W-1:0] LO_IX  = IX_W'(2 + 2*a);
      localparam logic [IX_W-1:0] HI_IX  = IX_W'(3 + 2*a);
      localparam logic [IX_W-1:0] LEN_IX = IX_W'(6 + a);

      logic [ADDR_W-1:0] start_q;
      logic [LEN_W-1:0]  len_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_q <= '0;
            len_q   <= '0;
         end else if (we) begin
            if (widx == LO_IX) start_q[REG_W-1:0]      <= wdata;
            if (widx == HI_IX) start_q[ADDR_W-1:REG_W] <= wdata;
            if (widx == LEN_IX) len_q                  <= wdata[LEN_W-1:0];
         end
      end

      assign start_o[a] = start_q;
      assign len_o[a]   = len_q;
   end

endmodule

// File: rtl/pbk_ctl_regs.sv
module pbk_ctl_regs
   import pbk_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IX_W-1:0]   widx,
   input  logic [REG_W-1:0]  wdata,
   input  logic [1:0]        done_set,
   output logic              run_o,
   output logic              rewind_o,
   output logic [2:0]        flags_o,
   output logic [5:0]        fmt_o
);

   logic       run_q;
   logic [2:0] flags_q;
   logic [5:0] fmt_q;
   logic [2:0] ack;

   assign rewind_o = we && (widx == IX_CTRL) && wdata[1];
   assign ack      = (we && (widx == IX_STAT)) ? wdata[2:0] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         flags_q <= 3'b001;
         fmt_q   <= FMT_RESET;
      end else begin
         flags_q <= (flags_q & ~ack) | {done_set, 1'b0};
         if (we && (widx == IX_CTRL)) run_q <= wdata[0];
         if (we && (widx == IX_FMT))  fmt_q <= wdata[5:0];
      end
   end

   assign run_o   = run_q;
   assign flags_o = flags_q;
   assign fmt_o   = fmt_q;

endmodule

// File: rtl/pbk_walker.sv
module pbk_walker
   import pbk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    rewind,
   input  logic                    fetch_req,
   input  logic                    wide,
   input  logic                    stereo,
   input  logic [1:0][ADDR_W-1:0]  start_i,
   input  logic [1:0][LEN_W-1:0]   len_i,
   output logic                    fetch_valid,
   output logic [ADDR_W-1:0]       pos_o,
   output logic [LEN_W-1:0]        off_o,
   output logic                    act_o,
   output logic [2:0]              step_o,
   output logic [1:0]              done_set
);

   logic [ADDR_W-1:0] pos_q;
   logic [LEN_W-1:0]  off_q;
   logic              act_q;
   logic [2:0]        step;
   logic [LEN_W:0]    nxt_off;
   logic              wrap;

   assign step        = frame_bytes(wide, stereo);
   assign fetch_valid = fetch_req && run;
   assign nxt_off     = {1'b0, off_q} + (LEN_W+1)'(step);
   assign wrap        = fetch_valid && (nxt_off >= {1'b0, len_i[act_q]});
   assign done_set    = wrap ? (act_q ? 2'b10 : 2'b01) : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         off_q <= '0;
         act_q <= 1'b0;
      end else if (rewind) begin
         pos_q <= start_i[0];
         off_q <= '0;
         act_q <= 1'b0;
      end else if (fetch_valid) begin
         if (wrap) begin
            pos_q <= start_i[~act_q];
            off_q <= '0;
            act_q <= ~act_q;
         end else begin
            pos_q <= pos_q + ADDR_W'(step);
            off_q <= nxt_off[LEN_W-1:0];
         end
      end
   end

   assign pos_o  = pos_q;
   assign off_o  = off_q;
   assign act_o  = act_q;
   assign step_o = step;

endmodule

// File: rtl/pbk_dma_seq.sv
module pbk_dma_seq
   import pbk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int REG_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_idx,
   input  logic [15:0]        reg_wdata,
   output logic [15:0]        reg_rdata,
   input  logic               fetch_req,
   output logic               fetch_valid,
   output logic [31:0]        fetch_addr,
   output logic               irq
);

   if (ADDR_W != 2*REG_W) begin : g_bad_addr
      $error("pbk_dma_seq: ADDR_W must be twice REG_W");
   end
   if (LEN_W > REG_W) begin : g_bad_len
      $error("pbk_dma_seq: LEN_W must fit in one register word");
   end
   if (REG_W != 16 || ADDR_W != 32) begin : g_bad_port
      $error("pbk_dma_seq: port widths assume 16-bit words and 32-bit addresses");
   end

   logic [1:0][ADDR_W-1:0] start_w;
   logic [1:0][LEN_W-1:0]  len_w;
   logic                   run_w;
   logic                   rewind_w;
   logic [2:0]             flags_w;
   logic [5:0]             fmt_w;
   logic [ADDR_W-1:0]      pos_w;
   logic [LEN_W-1:0]       off_w;
   logic                   act_w;
   logic [2:0]             step_w;
   logic [1:0]             done_w;

   pbk_area_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .widx    (reg_idx),
      .wdata   (reg_wdata),
      .start_o (start_w),
      .len_o   (len_w)
   );

   pbk_ctl_regs #(.REG_W(REG_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .widx     (reg_idx),
      .wdata    (reg_wdata),
      .done_set (done_w),
      .run_o    (run_w),
      .rewind_o (rewind_w),
      .flags_o  (flags_w),
      .fmt_o    (fmt_w)
   );

   pbk_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_w),
      .rewind      (rewind_w),
      .fetch_req   (fetch_req),
      .wide        (fmt_w[4]),
      .stereo      (fmt_w[5]),
      .start_i     (start_w),
      .len_i       (len_w),
      .fetch_valid (fetch_valid),
      .pos_o       (pos_w),
      .off_o       (off_w),
      .act_o       (act_w),
      .step_o      (step_w),
      .done_set    (done_w)
   );

   assign fetch_addr = pos_w;
   assign irq        = flags_w[1] | flags_w[2];

   always_comb begin
      case (reg_idx)
         IX_CTRL:   reg_rdata = {{(REG_W-1){1'b0}}, run_w};
         IX_STAT:   reg_rdata = {{(REG_W-3){1'b0}}, flags_w};
         IX_SA_LO:  reg_rdata = start_w[0][REG_W-1:0];
         IX_SA_HI:  reg_rdata = start_w[0][ADDR_W-1:REG_W];
         IX_SB_LO:  reg_rdata = start_w[1][REG_W-1:0];
         IX_SB_HI:  reg_rdata = start_w[1][ADDR_W-1:REG_W];
         IX_LEN_A:  reg_rdata = REG_W'(len_w[0]);
         IX_LEN_B:  reg_rdata = REG_W'(len_w[1]);
         IX_POS_LO: reg_rdata = pos_w[REG_W-1:0];
         IX_POS_HI: reg_rdata = pos_w[ADDR_W-1:REG_W];
         IX_OFS:    reg_rdata = REG_W'(off_w);
         IX_FMT:    reg_rdata = {{(REG_W-6){1'b0}}, fmt_w};
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pbk_dma_seq_chk.sv
module pbk_dma_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              rewind,
   input logic              fetch_valid,
   input logic              irq,
   input logic [ADDR_W-1:0] pos,
   input logic [LEN_W-1:0]  off,
   input logic              act,
   input logic [2:0]        step
);

   // R3
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !rewind) |=> (pos == $past(pos) && off == $past(off)));

   // R4
   rewind_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> (off == '0 && act == 1'b0));

   // R5
   advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !rewind) |=> (off == '0 || pos == $past(pos) + ADDR_W'($past(step))));

   // R6
   wrap_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !rewind) |=> (off != '0 || act != $past(act)));

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fetch_valid));

endmodule

bind pbk_dma_seq pbk_dma_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run         (run_w),
   .rewind      (rewind_w),
   .fetch_valid (fetch_valid),
   .irq         (irq),
   .pos         (pos_w),
   .off         (off_w),
   .act         (act_w),
   .step        (step_w)
);

// File: tb/pbk_dma_seq_tb_top.sv
module pbk_dma_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [3:0]  reg_idx;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic        fetch_req;
   logic        fetch_valid;
   logic [31:0] fetch_addr;
   logic        irq;

   always #5 clk = ~clk;

   pbk_dma_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_idx     (reg_idx),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .fetch_req   (fetch_req),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .irq         (irq)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state
   logic [31:0] m_s [2];
   logic [15:0] m_l [2];
   logic [31:0] m_pos;
   logic [15:0] m_off;
   int          m_act;
   bit          m_run;
   logic [5:0]  m_fmt;
   logic [2:0]  m_flags;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_read(input logic [3:0] idx);
      case (idx)
         4'd0:  return {15'b0, m_run};
         4'd1:  return {13'b0, m_flags};
         4'd2:  return m_s[0][15:0];
         4'd3:  return m_s[0][31:16];
         4'd4:  return m_s[1][15:0];
         4'd5:  return m_s[1][31:16];
         4'd6:  return m_l[0];
         4'd7:  return m_l[1];
         4'd8:  return m_pos[15:0];
         4'd9:  return m_pos[31:16];
         4'd10: return m_off;
         4'd11: return {10'b0, m_fmt};
         default: return 16'h0;
      endcase
   endfunction

   // one clock: drive, compare just after, then advance model at the edge
   task automatic cycle(input bit we, input logic [3:0] idx, input logic [15:0] wd,
                        input bit req, input string tag);
      int step;
      int noff;
      bit valid;
      bit wrap;
      logic [2:0] ack;
      reg_we = we; reg_idx = idx; reg_wdata = wd; fetch_req = req;
      #1;
      valid = req && m_run;
      chk("R3 fetch_valid", {31'b0, fetch_valid}, {31'b0, valid});
      if (valid) chk("R5 fetch_addr", fetch_addr, m_pos);
      chk("R8 irq", {31'b0, irq}, {31'b0, m_flags[1] | m_flags[2]});
      chk(tag, {16'b0, reg_rdata}, {16'b0, m_read(idx)});
      step = 1 << (int'(m_fmt[4]) + int'(m_fmt[5]));
      noff = int'(m_off) + step;
      wrap = valid && (noff >= int'(m_l[m_act]));
      ack  = (we && idx == 4'd1) ? wd[2:0] : 3'b000;
      @(posedge clk);
      m_flags = (m_flags & ~ack) | (wrap ? (m_act == 1 ? 3'b100 : 3'b010) : 3'b000);
      if (we && idx == 4'd0 && wd[1]) begin
         m_pos = m_s[0]; m_off = 16'h0; m_act = 0;
      end else if (valid) begin
         if (wrap) begin
            m_pos = m_s[1-m_act]; m_off = 16'h0; m_act = 1 - m_act;
         end else begin
            m_pos = m_pos + 32'(step); m_off = 16'(noff);
         end
      end
      if (we) begin
         case (idx)
            4'd0:  m_run = wd[0];
            4'd2:  m_s[0][15:0]  = wd;
            4'd3:  m_s[0][31:16] = wd;
            4'd4:  m_s[1][15:0]  = wd;
            4'd5:  m_s[1][31:16] = wd;
            4'd6:  m_l[0] = wd;
            4'd7:  m_l[1] = wd;
            4'd11: m_fmt = wd[5:0];
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [15:0] wd, input string tag);
      cycle(1'b1, idx, wd, 1'b0, tag);
   endtask

   task automatic rd(input logic [3:0] idx, input string tag);
      cycle(1'b0, idx, 16'h0, 1'b0, tag);
   endtask

   task automatic fetches(input int n, input bit gaps, input string tag);
      for (int i = 0; i < n; i++) begin
         cycle(1'b0, 4'd8, 16'h0, 1'b1, tag);
         if (gaps && (i % 3 == 1)) cycle(1'b0, 4'd10, 16'h0, 1'b0, tag);
      end
   endtask

   task automatic summary;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      m_s[0] = 0; m_s[1] = 0; m_l[0] = 0; m_l[1] = 0;
      m_pos = 0; m_off = 0; m_act = 0; m_run = 0; m_fmt = 6'h10; m_flags = 3'b001;
      rst_n = 1'b0; reg_we = 0; reg_idx = 0; reg_wdata = 0; fetch_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values through the read port
      for (int i = 0; i < 16; i++) rd(4'(i), "R1 reset read");
      reg_idx = 4'd1; #1; chk("R1 status reset", {16'b0, reg_rdata}, 32'h0001);
      reg_idx = 4'd11; #1; chk("R1 format reset", {16'b0, reg_rdata}, 32'h0010);
      chk("R1 irq low", {31'b0, irq}, 32'h0);
      @(negedge clk);

      // program both buffers (R2)
      wr(4'd2, 16'h0100, "R2 write"); wr(4'd3, 16'h1000, "R2 write");
      wr(4'd4, 16'h0200, "R2 write"); wr(4'd5, 16'h2000, "R2 write");
      wr(4'd6, 16'd8, "R2 write");    wr(4'd7, 16'd6, "R2 write");
      wr(4'd11, 16'h0000, "R9 fmt write");
      for (int i = 2; i < 8; i++) rd(4'(i), "R2 readback");

      // R4 rewind and start, bit1 reads back 0
      wr(4'd0, 16'h0003, "R4 rewind");
      rd(4'd0, "R4 ctrl readback");
      rd(4'd8, "R4 pos at start A");

      // R5/R6 8-bit mono, lengths 8 and 6
      fetches(20, 1'b0, "R6 walk mono8");
      rd(4'd1, "R6 both flags");
      wr(4'd1, 16'h0002, "R7 ack A");
      rd(4'd1, "R7 after ack A");

      // R5 16-bit mono, with gaps
      wr(4'd11, 16'h0010, "R9 fmt wide");
      fetches(10, 1'b1, "R5 walk wide");
      // R5 stereo 8-bit
      wr(4'd11, 16'h0020, "R9 fmt stereo");
      fetches(8, 1'b0, "R5 walk stereo");
      // R6 16-bit stereo: length 6 is not a multiple of 4
      wr(4'd11, 16'h0035, "R9 fmt wide stereo");
      fetches(8, 1'b0, "R6 walk frame4");
      rd(4'd10, "R6 offset");

      // R3 pause holds position
      wr(4'd0, 16'h0000, "R3 pause");
      fetches(4, 1'b0, "R3 paused");
      rd(4'd8, "R3 pos held"); rd(4'd10, "R3 off held");
      wr(4'd0, 16'h0001, "R3 resume");
      fetches(3, 1'b0, "R3 resumed");

      // R7 clear all with 0xFFFF, bit 0 clears, upper bits zero
      wr(4'd1, 16'hFFFF, "R7 ack all");
      rd(4'd1, "R7 status cleared");
      reg_idx = 4'd1; #1; chk("R7 status zero", {16'b0, reg_rdata}, 32'h0000);
      chk("R8 irq low after ack", {31'b0, irq}, 32'h0);
      @(negedge clk);

      // R10 writes to position and offset are ignored
      wr(4'd8, 16'hBEEF, "R10 pos lo write");
      wr(4'd9, 16'hDEAD, "R10 pos hi write");
      wr(4'd10, 16'h0033, "R10 off write");
      rd(4'd8, "R10 pos lo"); rd(4'd9, "R10 pos hi"); rd(4'd10, "R10 off");

      // R9 upper format bits fixed
      wr(4'd11, 16'hFFFF, "R9 fmt all ones");
      reg_idx = 4'd11; #1; chk("R9 fmt masked", {16'b0, reg_rdata}, 32'h003F);
      @(negedge clk);
      wr(4'd11, 16'h0000, "R9 fmt back");

      // R6 zero-length buffer: every fetch completes
      wr(4'd7, 16'd0, "R6 len B zero");
      wr(4'd0, 16'h0003, "R4 rewind again");
      fetches(12, 1'b1, "R6 zero length");

      // R7 set wins over clear in the same cycle
      wr(4'd1, 16'h0007, "R7 clear");
      wr(4'd0, 16'h0003, "R4 rewind");
      for (int i = 0; i < 7; i++) cycle(1'b0, 4'd1, 16'h0, 1'b1, "R6 fill A");
      cycle(1'b1, 4'd1, 16'h0002, 1'b1, "R7 ack with completion");
      rd(4'd1, "R7 flag survives");
      reg_idx = 4'd1; #1; chk("R7 set over clear", {16'b0, reg_rdata[1], 1'b0} & 32'h2, 32'h2);
      @(negedge clk);

      // R4 rewind beats a fetch in the same cycle
      cycle(1'b1, 4'd0, 16'h0003, 1'b1, "R4 rewind with fetch");
      rd(4'd8, "R4 pos after rewind"); rd(4'd10, "R4 off after rewind");

      summary();
      done = 1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule